// File: doc/BRIEF.md
# Audio Slot Transmit FIFO and Serializer

This block is the transmit side of a serial audio port. A bus master hands slot words in over a valid/ready write stream. The block stores them in a small first-in-first-out queue. One queue entry holds exactly one audio slot. Every accepted write takes one whole entry, whatever its access width, and narrow writes are never merged. Write data is right-aligned in the entry, and bits above the access width are cleared.

At each slot-start strobe the serializer pops one entry. It then sends the low bits of that entry, as many as the configured sample size, on `ser_out`, most significant of those bits first. It moves to the next bit on each bit-clock enable pulse. If no entry is waiting when a slot starts, the serializer sends zeros for that slot and raises a sticky underrun flag. The block also reports the queue level, full and empty flags, and a refill request. The request is high while the level is at or below a programmable threshold.

Write stream rules: a beat is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue is full. A beat offered while `wr_ready` is low is not stored and changes no state, and the master may hold it until space frees.

Top module: `audio_slot_tx`

## Requirements
- R1: The queue holds up to 8 entries of 32 bits. `level` runs from 0 to 8. `full` is high exactly when `level` is 8, and `empty` is high exactly when `level` is 0.
- R2: Each accepted write beat raises `level` by exactly one, whatever the access size, and occupies its own entry. Two narrow writes never share an entry.
- R3: While the queue is full, `wr_ready` is low, and an offered beat does not change `level` or any stored entry.
- R4: Stored data is right-aligned and zero-extended by `wr_size`: 0 keeps bits [7:0], 1 keeps bits [15:0], and 2 or 3 keep all 32 bits.
- R5: Entries leave in the order they were accepted.
- R6: A `slot_start` pulse with a non-empty queue pops one entry, and `level` drops by one in the next cycle. The cycle after the pulse, `ser_out` shows bit N-1 of that entry. After each `bit_tick` pulse it shows the next lower bit, down to bit 0.
- R7: `cfg_size` selects N: 0 gives 8, 1 gives 16, 2 gives 20, 3 gives 24, and 4 to 7 give 32.
- R8: After N `bit_tick` pulses, `slot_active` is low and `ser_out` is 0 until the next `slot_start`. `slot_active` is high while bits remain.
- R9: A `slot_start` pulse with an empty queue sends N zero bits and sets the sticky `underrun`. An `underrun_clr` pulse clears it, and a new underrun event in the same cycle wins.
- R10: `fifo_req` is high exactly when `level` is less than or equal to `cfg_thresh`.
- R11: After reset the queue is empty, `ser_out` and `slot_active` are 0, `underrun` is 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Queue can take a beat |
| wr_data | input | 32 | Right-aligned write data |
| wr_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| cfg_size | input | 3 | Sample size code (see R7) |
| cfg_thresh | input | 4 | Refill request threshold |
| slot_start | input | 1 | One-cycle slot start strobe |
| bit_tick | input | 1 | Bit clock enable, one cycle per bit |
| ser_out | output | 1 | Serial data, MSB first |
| slot_active | output | 1 | Bits of the current slot remain |
| level | output | 4 | Entries held, 0 to 8 |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| fifo_req | output | 1 | Level at or below threshold |
| underrun | output | 1 | Sticky: slot started on an empty queue |
| underrun_clr | input | 1 | Clear pulse for `underrun` |

## Verification
A pointer that slips by one shows up at the next slot as a wrong or repeated word on `ser_out`. It also shows within a cycle as `level` disagreeing with `full` or `empty`. A bad bit counter gives a slot that is short or long, or a misplaced first bit. This is visible at the first tick of the slot or at its end. A missing zero-extension shows as ones in the high part of a 20-, 24- or 32-bit slot built from a byte or halfword write. An overflow that slips through corrupts the order seen eight slots later.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  // sample size code to number of bits sent per slot
  function automatic logic [5:0] slot_bits(input logic [2:0] code);
    case (code)
      3'd0:    slot_bits = 6'd8;
      3'd1:    slot_bits = 6'd16;
      3'd2:    slot_bits = 6'd20;
      3'd3:    slot_bits = 6'd24;
      default: slot_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/wr_align.sv
module wr_align #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] din,
  input  logic [1:0]        acc,
  output logic [WORD_W-1:0] dout
);
  import audio_tx_pkg::*;
  localparam int LANES = WORD_W / 8;

  logic [LANES-1:0] keep;

  // lane enables: byte keeps lane 0, halfword lanes 0..1, word all
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (acc_size_e'(acc))
        ACC_BYTE: keep[g] = (g == 0);
        ACC_HALF: keep[g] = (g < 2);
        default:  keep[g] = 1'b1;
      endcase
    end
    assign dout[g*8 +: 8] = keep[g] ? din[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/slot_fifo.sv
module slot_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic [LW-1:0]     level
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty   = (wr_ptr == rd_ptr);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/slot_shifter.sv
module slot_shifter #(
  parameter int WORD_W = 32,
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              bit_tick,
  input  logic              have_data,
  input  logic [WORD_W-1:0] word,
  input  logic [CW-1:0]     nbits,
  output logic              pop,
  output logic              starve,
  output logic              ser_out,
  output logic              active
);
  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     left;
  logic [CW-1:0]     lshift;
  logic [WORD_W-1:0] aligned;

  assign pop     = slot_start && have_data;
  assign starve  = slot_start && !have_data;
  assign lshift  = CW'(WORD_W) - nbits;
  assign aligned = word << lshift;   // move bit nbits-1 to the top
  assign ser_out = sh[WORD_W-1];
  assign active  = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (slot_start) begin
      sh   <= have_data ? aligned : '0;
      left <= nbits;
    end else if (bit_tick && active) begin
      sh   <= sh << 1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/audio_slot_tx.sv
module audio_slot_tx #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  input  logic [2:0]        cfg_size,
  input  logic [LW-1:0]     cfg_thresh,
  input  logic              slot_start,
  input  logic              bit_tick,
  output logic              ser_out,
  output logic              slot_active,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              fifo_req,
  output logic              underrun,
  input  logic              underrun_clr
);
  import audio_tx_pkg::*;

  logic [WORD_W-1:0] ext_word, head_word;
  logic              pop, starve;
  logic [CW-1:0]     nbits;

  assign wr_ready = !full;
  assign nbits    = CW'(slot_bits(cfg_size));
  assign fifo_req = (level <= cfg_thresh);

  wr_align #(.WORD_W(WORD_W)) u_align (
    .din (wr_data),
    .acc (wr_size),
    .dout(ext_word)
  );

  slot_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (wr_valid && wr_ready),
    .wdata(ext_word),
    .pop  (pop),
    .rdata(head_word),
    .full (full),
    .empty(empty),
    .level(level)
  );

  slot_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_start(slot_start),
    .bit_tick  (bit_tick),
    .have_data (!empty),
    .word      (head_word),
    .nbits     (nbits),
    .pop       (pop),
    .starve    (starve),
    .ser_out   (ser_out),
    .active    (slot_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (starve)       underrun <= 1'b1;
    else if (underrun_clr) underrun <= 1'b0;
  end
endmodule

// File: rtl/audio_slot_tx_chk.sv
module audio_slot_tx_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          slot_start,
  input logic          ser_out,
  input logic          slot_active,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          underrun
);
  assert_full_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == LW'(DEPTH)));

  assert_empty_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (level == '0));

  assert_one_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !slot_start) |=> (level == $past(level) + 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !slot_start) |=> $stable(level));

  assert_pop_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !empty) |=> slot_active);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_active |-> !ser_out);

  assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && empty) |=> underrun);
endmodule

bind audio_slot_tx audio_slot_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .slot_start (slot_start),
  .ser_out    (ser_out),
  .slot_active(slot_active),
  .level      (level),
  .full       (full),
  .empty      (empty),
  .underrun   (underrun)
);

// File: tb/audio_slot_tx_bench.sv
`timescale 1ns/1ps
module audio_slot_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_size = '0;
  logic [2:0]  cfg_size = '0;
  logic [3:0]  cfg_thresh = 4'd3;
  logic        slot_start = 1'b0;
  logic        bit_tick = 1'b0;
  logic        ser_out, slot_active, full, empty, fifo_req, underrun;
  logic [3:0]  level;
  logic        underrun_clr = 1'b0;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] q [8];
  int qh = 0, qn = 0;
  bit exp_und = 0;

  always #2 clk = ~clk;

  audio_slot_tx u_audio_slot_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_size(wr_size), .cfg_size(cfg_size),
    .cfg_thresh(cfg_thresh), .slot_start(slot_start), .bit_tick(bit_tick),
    .ser_out(ser_out), .slot_active(slot_active), .level(level), .full(full),
    .empty(empty), .fifo_req(fifo_req), .underrun(underrun),
    .underrun_clr(underrun_clr)
  );

  function automatic int size_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 20;
      3'd3: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] extend(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return {24'h0, d[7:0]};
    if (s == 2'd1) return {16'h0, d[15:0]};
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags();
    chk(level == 4'(qn), "R1 level", 64'(level), 64'(qn));
    chk(full == (qn == 8), "R1 full", 64'(full), 64'(qn == 8));
    chk(empty == (qn == 0), "R1 empty", 64'(empty), 64'(qn == 0));
    chk(wr_ready == (qn != 8), "R3 ready", 64'(wr_ready), 64'(qn != 8));
    chk(fifo_req == (qn <= int'(cfg_thresh)), "R10 req", 64'(fifo_req), 64'(qn <= int'(cfg_thresh)));
    chk(underrun == exp_und, "R9 sticky", 64'(underrun), 64'(exp_und));
  endtask

  task automatic do_write(input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_size = s;
    chk(wr_ready == (qn != 8), "R3 ready before beat", 64'(wr_ready), 64'(qn != 8));
    @(negedge clk);
    wr_valid = 1'b0;
    if (qn < 8) begin
      q[(qh + qn) % 8] = extend(d, s);
      qn++;
    end
    check_flags();
  endtask

  task automatic do_slot(input logic [2:0] code);
    int n;
    logic [31:0] w;
    n = size_of(code);
    w = (qn > 0) ? q[qh] : 32'h0;
    @(negedge clk);
    cfg_size = code; slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    if (qn > 0) begin qh = (qh + 1) % 8; qn--; end
    else exp_und = 1;
    check_flags();
    for (int i = n - 1; i >= 0; i--) begin
      chk(ser_out == w[i], "R6 R7 serial bit", 64'(ser_out), 64'(w[i]));
      chk(slot_active == 1'b1, "R8 active", 64'(slot_active), 64'd1);
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    chk(slot_active == 1'b0, "R8 slot done", 64'(slot_active), 64'd0);
    chk(ser_out == 1'b0, "R8 idle low", 64'(ser_out), 64'd0);
  endtask

  task automatic clear_und();
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    exp_und = 0;
    check_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(empty && !full && level == 0 && wr_ready && !ser_out && !slot_active && !underrun,
        "R11 reset", {level, empty, full, wr_ready, ser_out, slot_active, underrun},
        {4'd0, 6'b101000});
    rst_n = 1'b1;
    check_flags();

    // R2 R4: two halfword writes use two entries, no packing
    do_write(32'hFFFF_1234, 2'd1);
    do_write(32'hFFFF_5678, 2'd1);
    chk(level == 4'd2, "R2 two entries", 64'(level), 64'd2);
    do_slot(3'd4);   // 32-bit slot: upper half must be zero (R4)
    do_slot(3'd3);   // 24-bit slot
    // R4 byte write seen through a 20-bit slot
    do_write(32'hABCD_EF5A, 2'd0);
    do_slot(3'd2);

    // R1 R3 fill, then attempt overflow, order kept (R5)
    for (int i = 0; i < 8; i++) do_write(32'hA000_0000 + 32'(i), 2'd2);
    do_write(32'hDEAD_BEEF, 2'd2);
    chk(level == 4'd8, "R3 no load when full", 64'(level), 64'd8);
    for (int i = 0; i < 8; i++) do_slot(3'd5);   // R5 order, R7 code 5 is 32 bits

    // R9 underrun on empty, clear, set again
    do_slot(3'd0);
    clear_und();
    do_slot(3'd1);
    // R9 set wins over clear in the same cycle
    @(negedge clk); slot_start = 1'b1; underrun_clr = 1'b1; cfg_size = 3'd0;
    @(negedge clk); slot_start = 1'b0; underrun_clr = 1'b0; exp_und = 1;
    chk(underrun == 1'b1, "R9 set wins", 64'(underrun), 64'd1);
    repeat (8) begin @(negedge clk); bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; end
    clear_und();

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) do_write($urandom, 2'($urandom_range(0, 3)));
      else if (op < 9) do_slot(3'($urandom_range(0, 7)));
      else begin
        cfg_thresh = 4'($urandom_range(0, 8));
        @(negedge clk);
        check_flags();
        if (exp_und) clear_und();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule